// File: doc/BRIEF.md
# Run-Time Controlled Multiply-Accumulate Element

This block is one registered multiply-accumulate slice for building DSP datapaths. Two operands are captured in input registers. Each register can take its value either from its own data port or from the operand register of the element before it in a chain. The captured operand values are always visible on cascade outputs, so a row of these elements forms a tapped delay line for FIR-style filters.

The operand width is set by a parameter to 9, 18 or 36 bits. Three controls travel through the pipeline beside the operands and may change on any cycle: how the multiplier treats the operands (two's complement or unsigned), whether the product is added to or subtracted from the accumulator, and where the operands are loaded from. The element can also run as a plain multiplier, in which case the accumulator register holds only the latest extended product. Synchronous load and clear inputs restart an accumulation. A clock enable holds the whole element. A synchronous reset and an asynchronous active-low reset clear it.

The accumulator has 16 guard bits above the full product width and wraps on overflow. Results appear two clock edges after the operands are presented.

Top module: `dyn_mac_elem`

## Requirements
- R1: While rst_ni is low, every register is zero, so acc_o, prod_o, a_cas_o and b_cas_o all read 0.
- R2: With load_sel_i=0, an enabled edge captures a_i and b_i into the operand registers, and a_cas_o/b_cas_o show them after that edge.
- R3: With load_sel_i=1, an enabled edge captures a_cas_i and b_cas_i in place of a_i and b_i.
- R4: With signed_i=0, prod_o is the unsigned product of the two operands, 2*OP_W bits wide.
- R5: With signed_i=1, both operands are read as two's complement, and prod_o holds the low 2*OP_W bits of the signed product.
- R6: With acc_mode_i=1, sub_i=0 adds the product to acc_o and sub_i=1 subtracts it. The product is sign-extended when signed_i=1 and zero-extended when signed_i=0.
- R7: With acc_mode_i=0 (plain multiply), acc_o takes the extended product and ignores its previous value.
- R8: acc_load_i=1 replaces the accumulator contents with the extended product and does not add to them.
- R9: acc_clr_i=1 sets the accumulator to zero. It takes priority over acc_load_i and over accumulation.
- R10: signed_i, sub_i, acc_mode_i, acc_load_i and acc_clr_i are registered together with the operands, so that each cycle's controls apply to that cycle's operands even when they change every cycle.
- R11: While ce_i=0, every register keeps its value.
- R12: srst_i=1 clears every register at the next edge, even when ce_i=0.
- R13: acc_o is 2*OP_W+16 bits wide and wraps modulo 2^(2*OP_W+16) without saturating.
- R14: Operands presented before edge k show in prod_o and acc_o after edge k+1, and not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for all registers |
| srst_i | input | 1 | Synchronous clear of all registers |
| a_i | input | OP_W | Parallel operand A |
| b_i | input | OP_W | Parallel operand B |
| a_cas_i | input | OP_W | Operand A from the previous element |
| b_cas_i | input | OP_W | Operand B from the previous element |
| load_sel_i | input | 1 | 0: load from a_i/b_i, 1: load from the cascade inputs |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| sub_i | input | 1 | 1: subtract the product, 0: add it |
| acc_mode_i | input | 1 | 1: accumulate, 0: plain multiply |
| acc_load_i | input | 1 | Load the accumulator with the product |
| acc_clr_i | input | 1 | Clear the accumulator |
| a_cas_o | output | OP_W | Current operand A register |
| b_cas_o | output | OP_W | Current operand B register |
| prod_o | output | 2*OP_W | Registered product |
| acc_o | output | 2*OP_W+16 | Accumulator |

## Verification
The case that matters is acc_clr_i and acc_load_i asserted with the same operand set. A 6x6 product is driven with both controls high, and acc_o must read zero two edges later. The next cycle raises load alone and must give 36, which shows that clear has priority and that neither control is latched. The same question of which control wins arises when srst_i is high while ce_i is low: the bench drives this pair and expects a cleared element, not a frozen one.

// File: rtl/dyn_mac_pkg.sv
package dyn_mac_pkg;
  typedef struct packed {
    logic sgn;
    logic sub;
    logic acc_en;
    logic ld;
    logic clr;
  } mac_ctrl_t;
endpackage

// File: rtl/dyn_mac_opreg.sv
module dyn_mac_opreg #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic         sel_i,
  input  logic [W-1:0] par_i,
  input  logic [W-1:0] cas_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (srst_i) q <= '0;
    else if (ce_i)   q <= sel_i ? cas_i : par_i;
  end

  assign q_o = q;

  AST_PAR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && !sel_i |=> q_o == $past(par_i)); // R2
  AST_SHIFT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && sel_i |=> q_o == $past(cas_i)); // R3
endmodule

// File: rtl/dyn_mac_mult.sv
module dyn_mac_mult #(
  parameter int W = 18,
  localparam int PF_W = 2*W + 2
) (
  input  logic            sgn_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [PF_W-1:0] p_o
);
  // one extra bit per operand lets a single signed multiplier serve both modes
  logic signed [W:0]      a_x, b_x;
  logic signed [PF_W-1:0] p;

  assign a_x = {sgn_i & a_i[W-1], a_i};
  assign b_x = {sgn_i & b_i[W-1], b_i};
  assign p   = a_x * b_x;
  assign p_o = p;
endmodule

// File: rtl/dyn_mac_accum.sv
module dyn_mac_accum
  import dyn_mac_pkg::*;
#(
  parameter int W     = 18,
  parameter int GUARD = 16,
  localparam int PF_W  = 2*W + 2,
  localparam int P_W   = 2*W,
  localparam int ACC_W = 2*W + GUARD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             srst_i,
  input  mac_ctrl_t        ctrl_i,
  input  logic [PF_W-1:0]  pfull_i,
  output logic [P_W-1:0]   prod_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] ext_prod, acc_d, acc_q;
  logic [P_W-1:0]   prod_q;

  assign ext_prod = {{(ACC_W-PF_W){pfull_i[PF_W-1]}}, pfull_i};

  always_comb begin
    if (ctrl_i.clr)                     acc_d = '0;
    else if (ctrl_i.ld || !ctrl_i.acc_en) acc_d = ext_prod;
    else if (ctrl_i.sub)                acc_d = acc_q - ext_prod;
    else                                acc_d = acc_q + ext_prod;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      prod_q <= '0;
    end else if (srst_i) begin
      acc_q  <= '0;
      prod_q <= '0;
    end else if (ce_i) begin
      acc_q  <= acc_d;
      prod_q <= pfull_i[P_W-1:0];
    end
  end

  assign acc_o  = acc_q;
  assign prod_o = prod_q;

  AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i && !srst_i |=> $stable(acc_o) && $stable(prod_o)); // R11
  AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> acc_o == '0 && prod_o == '0); // R12
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && ctrl_i.clr |=> acc_o == '0); // R9
  AST_PLAIN_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && !ctrl_i.clr && !ctrl_i.acc_en |=> acc_o == $past(ext_prod)); // R7
  AST_ACC_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && ctrl_i.acc_en && !ctrl_i.ld && !ctrl_i.clr && !ctrl_i.sub
    |=> acc_o == $past(acc_o) + $past(ext_prod)); // R6
  AST_ACC_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i && ctrl_i.acc_en && !ctrl_i.ld && !ctrl_i.clr && ctrl_i.sub
    |=> acc_o == $past(acc_o) - $past(ext_prod)); // R6
endmodule

// File: rtl/dyn_mac_elem.sv
module dyn_mac_elem
  import dyn_mac_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int GUARD = 16,
  localparam int P_W   = 2*OP_W,
  localparam int PF_W  = 2*OP_W + 2,
  localparam int ACC_W = 2*OP_W + GUARD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             srst_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic [OP_W-1:0]  a_cas_i,
  input  logic [OP_W-1:0]  b_cas_i,
  input  logic             load_sel_i,
  input  logic             signed_i,
  input  logic             sub_i,
  input  logic             acc_mode_i,
  input  logic             acc_load_i,
  input  logic             acc_clr_i,
  output logic [OP_W-1:0]  a_cas_o,
  output logic [OP_W-1:0]  b_cas_o,
  output logic [P_W-1:0]   prod_o,
  output logic [ACC_W-1:0] acc_o
);
  generate
    if (OP_W != 9 && OP_W != 18 && OP_W != 36) begin : g_bad_width
      $error("dyn_mac_elem: OP_W must be 9, 18 or 36");
    end
  endgenerate

  logic [OP_W-1:0] a_q, b_q;
  logic [PF_W-1:0] pfull;
  mac_ctrl_t       ctrl_d, ctrl_q;

  dyn_mac_opreg #(.W(OP_W)) u_areg (
    .clk_i, .rst_ni, .ce_i, .srst_i,
    .sel_i(load_sel_i), .par_i(a_i), .cas_i(a_cas_i), .q_o(a_q)
  );

  dyn_mac_opreg #(.W(OP_W)) u_breg (
    .clk_i, .rst_ni, .ce_i, .srst_i,
    .sel_i(load_sel_i), .par_i(b_i), .cas_i(b_cas_i), .q_o(b_q)
  );

  // controls ride with their operand set through stage 1
  assign ctrl_d = '{sgn: signed_i, sub: sub_i, acc_en: acc_mode_i,
                    ld: acc_load_i, clr: acc_clr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (srst_i) ctrl_q <= '0;
    else if (ce_i)   ctrl_q <= ctrl_d;
  end

  dyn_mac_mult #(.W(OP_W)) u_mult (
    .sgn_i(ctrl_q.sgn), .a_i(a_q), .b_i(b_q), .p_o(pfull)
  );

  dyn_mac_accum #(.W(OP_W), .GUARD(GUARD)) u_acc (
    .clk_i, .rst_ni, .ce_i, .srst_i,
    .ctrl_i(ctrl_q), .pfull_i(pfull), .prod_o(prod_o), .acc_o(acc_o)
  );

  assign a_cas_o = a_q;
  assign b_cas_o = b_q;

  AST_CTRL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !srst_i |=> ctrl_q == $past(ctrl_d)); // R10
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> acc_o == '0 && prod_o == '0 && a_cas_o == '0 && b_cas_o == '0); // R1
endmodule

// File: tb/dyn_mac_elem_test.sv
module dyn_mac_elem_test;
  localparam int W  = 18;
  localparam int PW = 36;
  localparam int AW = 52;
  localparam longint unsigned MP = (64'd1 << PW) - 1;
  localparam longint unsigned MA = (64'd1 << AW) - 1;

  logic clk = 0, rst_ni = 0, ce = 1, srst = 0;
  logic [W-1:0] a = 0, b = 0, ac = 0, bc = 0;
  logic sel = 0, sgn = 0, sub = 0, mode = 0, ld = 0, clr = 0;
  logic [W-1:0]  a_cas_o, b_cas_o;
  logic [PW-1:0] prod_o;
  logic [AW-1:0] acc_o;

  int checks = 0, errors = 0;

  // reference model state
  logic [W-1:0] m_a = 0, m_b = 0;
  bit m_s, m_sub, m_en, m_ld, m_clr;
  longint unsigned m_prod = 0, m_acc = 0;

  always #10 clk = ~clk;

  dyn_mac_elem uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .srst_i(srst),
    .a_i(a), .b_i(b), .a_cas_i(ac), .b_cas_i(bc),
    .load_sel_i(sel), .signed_i(sgn), .sub_i(sub), .acc_mode_i(mode),
    .acc_load_i(ld), .acc_clr_i(clr),
    .a_cas_o(a_cas_o), .b_cas_o(b_cas_o), .prod_o(prod_o), .acc_o(acc_o)
  );

  function automatic longint ext(logic [W-1:0] v, bit s);
    return s ? longint'($signed(v)) : longint'({46'b0, v});
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] va, logic [W-1:0] vb, bit vsgn, bit vmode,
                       bit vsub, bit vld, bit vclr);
    a = va; b = vb; sgn = vsgn; mode = vmode; sub = vsub; ld = vld; clr = vclr;
  endtask

  task automatic tick();
    longint p;
    @(posedge clk);
    if (srst) begin
      m_a = 0; m_b = 0; m_prod = 0; m_acc = 0;
      {m_s, m_sub, m_en, m_ld, m_clr} = '0;
    end else if (ce) begin
      p = ext(m_a, m_s) * ext(m_b, m_s);
      m_prod = p & MP;
      if (m_clr)              m_acc = 0;
      else if (m_ld || !m_en) m_acc = p & MA;
      else if (m_sub)         m_acc = (m_acc - p) & MA;
      else                    m_acc = (m_acc + p) & MA;
      m_a = sel ? ac : a;
      m_b = sel ? bc : b;
      {m_s, m_sub, m_en, m_ld, m_clr} = {sgn, sub, mode, ld, clr};
    end
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " acc"}, acc_o, m_acc);
    chk({tag, " prod"}, prod_o, m_prod);
    chk({tag, " a_cas"}, a_cas_o, m_a);
    chk({tag, " b_cas"}, b_cas_o, m_b);
  endtask

  task automatic t_reset();
    chk("R1 acc in reset", acc_o, 0);
    chk("R1 prod in reset", prod_o, 0);
    chk("R1 cas in reset", {a_cas_o, b_cas_o}, 0);
    rst_ni = 1;
  endtask

  task automatic t_latency();
    drive(5, 7, 0, 0, 0, 0, 0);
    tick();
    chk("R14 acc not yet after first edge", acc_o, 0);
    chk("R2 a_cas after capture", a_cas_o, 5);
    drive(0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R14 acc after second edge", acc_o, 35);
    chk("R4 prod small unsigned", prod_o, 35);
  endtask

  task automatic t_unsigned_big();
    drive(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 0);
    tick(); drive(0, 0, 0, 0, 0, 0, 0); tick();
    chk("R4 prod max unsigned", prod_o, 64'h3FFFF * 64'h3FFFF);
    chk("R7 plain acc zero-extended", acc_o, 64'h3FFFF * 64'h3FFFF);
  endtask

  task automatic t_signed();
    drive(18'h3FFFD, 18'd4, 1, 0, 0, 0, 0);
    tick();
    drive(18'h3FFFD, 18'd4, 0, 0, 0, 0, 0);
    tick();
    chk("R5 signed prod -12", prod_o, (-64'sd12) & MP);
    chk("R5 signed acc -12", acc_o, (-64'sd12) & MA);
    tick();
    chk("R4 same operands unsigned", prod_o, 64'h3FFFD * 4);
  endtask

  task automatic t_accum();
    drive(10, 10, 0, 1, 0, 1, 0); tick();
    drive(3, 3, 0, 1, 0, 0, 0);   tick();
    chk("R8 load gives product", acc_o, 100);
    drive(2, 2, 0, 1, 1, 0, 0);   tick();
    chk("R6 add 9", acc_o, 109);
    drive(18'h3FFFF, 1, 1, 1, 0, 0, 0); tick();
    chk("R6 sub 4", acc_o, 105);
    drive(0, 0, 0, 1, 0, 0, 0);   tick();
    chk("R6 add signed -1", acc_o, 104);
    check_all("R6 model");
  endtask

  task automatic t_clear();
    drive(6, 6, 0, 1, 0, 1, 1); tick();
    drive(6, 6, 0, 1, 0, 1, 0); tick();
    chk("R9 clear wins over load", acc_o, 0);
    drive(1, 1, 0, 1, 0, 0, 0); tick();
    chk("R9 load after clear", acc_o, 36);
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    chk("R6 add after load", acc_o, 37);
  endtask

  task automatic t_dynamic();
    for (int i = 0; i < 10; i++) begin
      drive(18'h3FFF0 + 18'(i), 18'(i * 3 + 1), bit'(i % 2), 1, bit'((i / 2) % 2), i == 0, 0);
      tick();
      check_all("R10 per-cycle controls");
    end
  endtask

  task automatic t_shift();
    sel = 1; ac = 18'h155; bc = 18'h0AA; a = 18'h2AA; b = 18'h3;
    mode = 0; ld = 0; clr = 0;
    tick();
    chk("R3 shift load a", a_cas_o, 18'h155);
    chk("R3 shift load b", b_cas_o, 18'h0AA);
    sel = 0;
    tick();
    chk("R2 parallel load a", a_cas_o, 18'h2AA);
    chk("R3 product of cascaded operands", prod_o, 64'h155 * 64'h0AA);
  endtask

  task automatic t_ce();
    longint unsigned acc0;
    drive(9, 9, 0, 1, 0, 0, 0); tick(); tick();
    acc0 = acc_o;
    ce = 0;
    for (int i = 0; i < 3; i++) begin
      drive(18'(i + 20), 18'(i + 30), 1, 1, 1, 0, 1);
      tick();
      chk("R11 acc held", acc_o, acc0);
      check_all("R11 all held");
    end
    ce = 1;
  endtask

  task automatic t_srst();
    drive(4, 4, 0, 1, 0, 0, 0); tick(); tick();
    ce = 0; srst = 1;
    tick();
    chk("R12 acc cleared with ce low", acc_o, 0);
    chk("R12 prod cleared", prod_o, 0);
    chk("R12 cas cleared", {a_cas_o, b_cas_o}, 0);
    srst = 0; ce = 1;
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    chk("R12 ctrl cleared, acc stays 0", acc_o, 0);
  endtask

  task automatic t_wrap();
    drive(1, 1, 0, 1, 0, 0, 1); tick();
    drive(1, 1, 0, 1, 1, 0, 0); tick();
    drive(1, 1, 0, 1, 0, 0, 0); tick();
    chk("R13 wrap below zero", acc_o, MA);
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    chk("R13 wrap back to zero", acc_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_latency();
    t_unsigned_big();
    t_signed();
    t_accum();
    t_clear();
    t_dynamic();
    t_shift();
    t_ce();
    t_srst();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule